// File: doc/BRIEF.md
# Four-Rail Power Sequencing Controller

This block switches the enables of four power rails on and off in a programmable order. It watches four undervoltage-OK flags and a start input. The flags are already digitised comparator outputs. A short dip on a flag is filtered out. A dip that lasts long enough is a fault.

Each rail has its own turn-on delay and its own turn-off delay, both counted in clock ticks. The turn-on and turn-off orders can therefore differ. When every rail is on and a hold time has passed, an active-low "sequence complete" output asserts.

A shared system-reset line lets several controllers be chained. The line is modelled as a drive-low output plus the sensed wired-AND level. Pulling the line low kills every gate at once. Releasing it from outside starts a new turn-on sequence with no settling wait. The controller pulls the line low itself while any of its own monitors reports a fault.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is held, and until the monitors have been seen valid, all gates are low, `seq_done_n_o` is 1 and `sysrst_drive_o` is 1.
- R2: A monitor low lasting fewer than FILT_TICKS consecutive clock samples has no effect on any output. Exactly FILT_TICKS consecutive low samples count as a fault.
- R3: On a filtered monitor fault, `sysrst_drive_o` goes to 1 and `seq_done_n_o` goes to 1 in the same cycle. All gates are low one edge later.
- R4: When the controller's own monitors release the line, the next STAB_TICKS edges form a settling window in which the enable input is ignored. Take the first edge that sees the line high as edge 0. If enable is high at edge STAB_TICKS, a sequence starts there, and gate i is first high after edge STAB_TICKS+1+d_i. If enable is low at that edge, the block waits idle with all gates off.
- R5: From idle with enable raised, take the first edge that sees enable high as edge 0. Gate i is first high after edge d_i+1, where d_i is on_dly_i[i*DLY_W +: DLY_W] (channel 0 in the low bits).
- R6: When enable falls, take the first edge that sees it low as edge 0. Each gate that is on goes low after edge f_i+1, where f_i is off_dly_i[i*DLY_W +: DLY_W].
- R7: `seq_done_n_o` goes to 0 after edge max(d)+2+DONE_TICKS, counted as in R5. It returns to 1 in the same cycle that enable falls.
- R8: A low sensed level on `sysrst_in_i` clears every gate at the next edge. No turn-off delay is applied, and the controller does not itself drive the line.
- R9: When another driver releases the line and enable is high, the first edge that sees the line high is edge 0. Gate i is then first high after edge d_i+1, with no settling window.
- R10: If enable falls before all gates are on, gates not yet on stay off. Gates already on turn off by their own off delays, as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uv_ok_i | input | NCH | Per-rail undervoltage-OK flags, 1 = rail good |
| enable_i | input | 1 | Start (1) / shut down (0) request |
| on_dly_i | input | NCH*DLY_W | Packed per-rail turn-on delays in ticks |
| off_dly_i | input | NCH*DLY_W | Packed per-rail turn-off delays in ticks |
| sysrst_in_i | input | 1 | Sensed level of the shared reset line (wired-AND) |
| sysrst_drive_o | output | 1 | 1 = pull the shared reset line low |
| gate_o | output | NCH | Rail enable outputs |
| seq_done_n_o | output | 1 | Active-low sequence-complete flag |

## Verification
Rising gate edges fall due d_i+1 edges after the start edge, or STAB_TICKS+1+d_i edges after release when the settling window applies. Falling edges fall due f_i+1 edges after enable drops. Sequence complete falls due max(d)+2+DONE_TICKS edges after the start edge. A fault kills the gates one edge after the FILT_TICKS-th low sample.

The bench drives and samples at the falling clock edge. It numbers every rising edge from the first one that sees the stimulus, and compares the index at which each output first changes with the index computed by its own functions. The combinational responses are sampled in the same half cycle as the stimulus: sequence complete clearing on enable loss, and drive and sequence complete reacting to a filtered fault.

// File: rtl/rail_seq_pkg.sv
// Shared types and helpers for the rail sequencer.
package rail_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STABILISE,
        ST_SEQ_ON,
        ST_ALL_ON,
        ST_RESET_WAIT,
        ST_DONE,
        ST_SEQ_OFF,
        ST_FAULT_OFF
    } seq_state_e;

    // Larger of two integers, used for width derivation.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/uv_deglitch.sv
// Deglitch filter for one undervoltage-OK flag.
// Assumes the input is already synchronous to clk. A high sample
// restores "good" at the next edge. FILT_TICKS consecutive low samples
// are needed before "good" is withdrawn. Resets to "not good".
module uv_deglitch #(
    parameter int FILT_TICKS = 7500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_ok_i,
    output logic filt_ok_o
);
    localparam int CW = $clog2(FILT_TICKS) + 1;

    logic [CW-1:0] low_cnt;

    // Count consecutive low samples and drop the flag on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt   <= '0;
            filt_ok_o <= 1'b0;
        end else if (raw_ok_i) begin
            low_cnt   <= '0;
            filt_ok_o <= 1'b1;
        end else if (low_cnt == CW'(FILT_TICKS - 1)) begin
            filt_ok_o <= 1'b0;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rail_gate.sv
// One rail enable. It is set while turn-on is active and the shared
// timer has reached the rail's on delay. It is cleared while turn-off is
// active and the timer has reached its off delay. Kill clears it with
// priority. Exposes the next value so the sequencer can see completion
// one edge early.
module rail_gate #(
    parameter int DLY_W = 8,
    parameter int TMR_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kill_i,
    input  logic             on_en_i,
    input  logic             off_en_i,
    input  logic [TMR_W-1:0] tmr_i,
    input  logic [DLY_W-1:0] on_dly_i,
    input  logic [DLY_W-1:0] off_dly_i,
    output logic             gate_nxt_o,
    output logic             gate_o
);
    logic [TMR_W-1:0] on_ext, off_ext;

    assign on_ext  = TMR_W'(on_dly_i);
    assign off_ext = TMR_W'(off_dly_i);

    // Next gate value, with kill as the highest priority.
    always_comb begin
        gate_nxt_o = gate_o;
        if (kill_i)
            gate_nxt_o = 1'b0;
        else if (on_en_i && (tmr_i >= on_ext))
            gate_nxt_o = 1'b1;
        else if (off_en_i && (tmr_i >= off_ext))
            gate_nxt_o = 1'b0;
    end

    // Gate register.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_o <= 1'b0;
        else        gate_o <= gate_nxt_o;
    end
endmodule

// File: rtl/seq_fsm.sv
// Sequencer state machine with a shared saturating tick timer.
// The timer restarts at zero on every state change. A low reset line
// forces FAULT_OFF from any state. Leaving FAULT_OFF takes one of two
// paths: through the settling window when the controller's own drive
// was active, or straight to turn-on when another driver released the line.
module seq_fsm
    import rail_seq_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int TMR_W      = 27,
    parameter int STAB_TICKS = 2500000,
    parameter int DONE_TICKS = 37500000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             line_i,
    input  logic             own_drv_i,
    input  logic [NCH-1:0]   gates_nxt_i,
    output seq_state_e       state_o,
    output logic [TMR_W-1:0] tmr_o
);
    seq_state_e nxt;
    logic       drv_q;

    // Next-state decision.
    always_comb begin
        nxt = state_o;
        if (!line_i) begin
            nxt = ST_FAULT_OFF;
        end else begin
            unique case (state_o)
                ST_FAULT_OFF:  nxt = drv_q ? ST_STABILISE
                                           : (enable_i ? ST_SEQ_ON : ST_IDLE);
                ST_IDLE:       if (enable_i) nxt = ST_SEQ_ON;
                ST_STABILISE:  if (tmr_o == TMR_W'(STAB_TICKS - 1))
                                   nxt = enable_i ? ST_SEQ_ON : ST_IDLE;
                ST_SEQ_ON:     if (!enable_i) nxt = ST_SEQ_OFF;
                               else if (&gates_nxt_i) nxt = ST_ALL_ON;
                ST_ALL_ON:     nxt = enable_i ? ST_RESET_WAIT : ST_SEQ_OFF;
                ST_RESET_WAIT: if (!enable_i) nxt = ST_SEQ_OFF;
                               else if (tmr_o == TMR_W'(DONE_TICKS - 1))
                                   nxt = ST_DONE;
                ST_DONE:       if (!enable_i) nxt = ST_SEQ_OFF;
                ST_SEQ_OFF:    if (gates_nxt_i == '0) nxt = ST_IDLE;
                default:       nxt = ST_FAULT_OFF;
            endcase
        end
    end

    // State, timer and remembered own-drive registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= ST_FAULT_OFF;
            tmr_o   <= '0;
            drv_q   <= 1'b1;
        end else begin
            state_o <= nxt;
            drv_q   <= own_drv_i;
            if (nxt != state_o)
                tmr_o <= '0;
            else if (tmr_o != '1)
                tmr_o <= tmr_o + 1'b1;
        end
    end
endmodule

// File: rtl/rail_sequencer.sv
// Four-rail power sequencing controller (top).
// It deglitches each monitor flag, drives the shared reset line low
// while any filtered monitor is bad, and sequences the rail enables
// with per-rail tick delays. Inputs are assumed synchronous to clk.
// sysrst_in_i is the wired-AND of every driver, this one included.
module rail_sequencer
    import rail_seq_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int DLY_W      = 8,
    parameter int FILT_TICKS = 7500,
    parameter int STAB_TICKS = 2500000,
    parameter int DONE_TICKS = 37500000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       uv_ok_i,
    input  logic                 enable_i,
    input  logic [NCH*DLY_W-1:0] on_dly_i,
    input  logic [NCH*DLY_W-1:0] off_dly_i,
    input  logic                 sysrst_in_i,
    output logic                 sysrst_drive_o,
    output logic [NCH-1:0]       gate_o,
    output logic                 seq_done_n_o
);
    localparam int TMR_W = imax(imax($clog2(STAB_TICKS) + 1,
                                     $clog2(DONE_TICKS) + 1), DLY_W + 1);

    logic [NCH-1:0]   filt_ok;
    logic [NCH-1:0]   gates_nxt;
    logic             all_ok;
    logic             on_en, off_en;
    seq_state_e       state;
    logic [TMR_W-1:0] tmr;

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_chan
            uv_deglitch #(.FILT_TICKS(FILT_TICKS)) u_flt (
                .clk       (clk),
                .rst_n     (rst_n),
                .raw_ok_i  (uv_ok_i[g]),
                .filt_ok_o (filt_ok[g])
            );
            rail_gate #(.DLY_W(DLY_W), .TMR_W(TMR_W)) u_gate (
                .clk        (clk),
                .rst_n      (rst_n),
                .kill_i     (!sysrst_in_i),
                .on_en_i    (on_en),
                .off_en_i   (off_en),
                .tmr_i      (tmr),
                .on_dly_i   (on_dly_i[g*DLY_W +: DLY_W]),
                .off_dly_i  (off_dly_i[g*DLY_W +: DLY_W]),
                .gate_nxt_o (gates_nxt[g]),
                .gate_o     (gate_o[g])
            );
        end
    endgenerate

    seq_fsm #(
        .NCH(NCH), .TMR_W(TMR_W),
        .STAB_TICKS(STAB_TICKS), .DONE_TICKS(DONE_TICKS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .line_i      (sysrst_in_i),
        .own_drv_i   (sysrst_drive_o),
        .gates_nxt_i (gates_nxt),
        .state_o     (state),
        .tmr_o       (tmr)
    );

    // Monitor summary, line drive and per-phase gate enables.
    always_comb begin
        all_ok         = &filt_ok;
        sysrst_drive_o = !all_ok;
        on_en          = (state == ST_SEQ_ON) && enable_i;
        off_en         = (state == ST_SEQ_OFF);
        seq_done_n_o   = !((state == ST_DONE) && enable_i && all_ok);
    end
endmodule

// File: rtl/rail_sequencer_checker.sv
// Temporal checks on the sequencer's ports, bound to every instance.
module rail_sequencer_checker #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           enable_i,
    input logic           sysrst_in_i,
    input logic           sysrst_drive_o,
    input logic [NCH-1:0] gate_o,
    input logic           seq_done_n_o
);
    // R8: a low line leaves every gate off after the next edge.
    a_r8_line_kills_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !sysrst_in_i |=> (gate_o == '0));

    // R5 / R9: a gate can only rise after an edge that saw enable and the line high.
    a_r5_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (|(gate_o & ~$past(gate_o))) |-> ($past(enable_i) && $past(sysrst_in_i)));

    // R7: completion is reported only with every gate on.
    a_r7_done_all_on: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_done_n_o |-> (&gate_o));

    // R7: completion clears whenever enable is low.
    a_r7_done_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> seq_done_n_o);

    // R3: completion never coexists with the controller pulling the line.
    a_r3_done_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_done_n_o |-> !sysrst_drive_o);
endmodule

bind rail_sequencer rail_sequencer_checker #(.NCH(NCH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable_i       (enable_i),
    .sysrst_in_i    (sysrst_in_i),
    .sysrst_drive_o (sysrst_drive_o),
    .gate_o         (gate_o),
    .seq_done_n_o   (seq_done_n_o)
);

// File: tb/rail_sequencer_bench.sv
module rail_sequencer_bench;
    localparam int NCH  = 4;
    localparam int DW   = 5;
    localparam int FILT = 4;
    localparam int STAB = 20;
    localparam int DONE = 30;
    localparam int LIM  = 200;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NCH-1:0]     uv_ok = '1;
    logic               enable = 1'b0;
    logic [NCH*DW-1:0]  on_dly, off_dly;
    logic               ext_rel = 1'b1;
    logic               line;
    logic               drive;
    logic [NCH-1:0]     gate;
    logic               done_n;
    logic [DW-1:0]      on_d  [NCH];
    logic [DW-1:0]      off_d [NCH];

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign line = ext_rel & ~drive;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            on_dly[i*DW +: DW]  = on_d[i];
            off_dly[i*DW +: DW] = off_d[i];
        end
    end

    rail_sequencer #(
        .NCH(NCH), .DLY_W(DW), .FILT_TICKS(FILT),
        .STAB_TICKS(STAB), .DONE_TICKS(DONE)
    ) u_rail_sequencer (
        .clk(clk), .rst_n(rst_n), .uv_ok_i(uv_ok), .enable_i(enable),
        .on_dly_i(on_dly), .off_dly_i(off_dly), .sysrst_in_i(line),
        .sysrst_drive_o(drive), .gate_o(gate), .seq_done_n_o(done_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_on_edge(input int base, input int d);
        return base + d + 1;
    endfunction

    function automatic int exp_done_edge(input int base);
        int m = 0;
        for (int i = 0; i < NCH; i++) if (int'(on_d[i]) > m) m = int'(on_d[i]);
        return base + m + 2 + DONE;
    endfunction

    // Record the edge index at which each gate rises and done falls.
    task automatic measure_on(input int base, input string req);
        int rise [NCH];
        int dn = -1;
        for (int i = 0; i < NCH; i++) rise[i] = -1;
        for (int k = 0; k < LIM && dn < 0; k++) begin
            tick();
            for (int i = 0; i < NCH; i++) if (gate[i] && rise[i] < 0) rise[i] = k;
            if (!done_n) dn = k;
        end
        for (int i = 0; i < NCH; i++)
            check(rise[i] == exp_on_edge(base, int'(on_d[i])), req, rise[i],
                  exp_on_edge(base, int'(on_d[i])));
        check(dn == exp_done_edge(base), "R7 done timing", dn, exp_done_edge(base));
    endtask

    // Drop enable and record the edge index of each gate's fall.
    task automatic measure_off(input logic [NCH-1:0] was_on, input string req);
        int fall [NCH];
        enable = 1'b0;
        #1;
        check(done_n == 1'b1, "R7 done clears with enable", done_n, 1);
        for (int i = 0; i < NCH; i++) fall[i] = -1;
        for (int k = 0; k < 40; k++) begin
            tick();
            for (int i = 0; i < NCH; i++) if (!gate[i] && fall[i] < 0) fall[i] = k;
        end
        for (int i = 0; i < NCH; i++) begin
            if (was_on[i])
                check(fall[i] == int'(off_d[i]) + 1, req, fall[i], int'(off_d[i]) + 1);
        end
        check(gate == '0, "R6 all off", gate, 0);
    endtask

    task automatic rand_delays();
        for (int i = 0; i < NCH; i++) begin
            on_d[i]  = DW'($urandom_range(0, (1 << DW) - 1));
            off_d[i] = DW'($urandom_range(0, (1 << DW) - 1));
        end
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < NCH; i++) begin
            on_d[i]  = DW'(3 + 4 * i);
            off_d[i] = DW'(12 - 3 * i);
        end
        enable = 1'b1;
        repeat (3) tick();
        // R1: reset state.
        check(gate == '0, "R1 gates in reset", gate, 0);
        check(done_n == 1'b1, "R1 done_n in reset", done_n, 1);
        check(drive == 1'b1, "R1 drive in reset", drive, 1);
        rst_n = 1'b1;
        tick();
        check(drive == 1'b0, "R1 drive released", drive, 0);
        // R4: settling window with enable held high.
        measure_on(STAB, "R4 rise after settling");
        measure_off('1, "R6 fall timing");

        // R5 / R6: random delays from idle.
        for (int it = 0; it < 8; it++) begin
            rand_delays();
            repeat (3) tick();
            enable = 1'b1;
            measure_on(0, "R5 rise timing");
            measure_off('1, "R6 fall timing");
        end

        // R10: abort during turn-on.
        on_d[0] = 5'd2;  on_d[1] = 5'd10; on_d[2] = 5'd20; on_d[3] = 5'd30;
        off_d[0] = 5'd5; off_d[1] = 5'd1;
        repeat (3) tick();
        enable = 1'b1;
        repeat (13) tick();
        check(gate == 4'b0011, "R10 partial on", gate, 3);
        measure_off(4'b0011, "R10 off of started gates");

        // Bring to done for the monitor tests.
        rand_delays();
        enable = 1'b1;
        measure_on(0, "R5 rise timing");
        // R2: glitch one sample short of the window.
        uv_ok[1] = 1'b0;
        repeat (FILT - 1) tick();
        uv_ok[1] = 1'b1;
        repeat (5) tick();
        check(gate == '1, "R2 glitch ignored gates", gate, 15);
        check(done_n == 1'b0, "R2 glitch ignored done", done_n, 0);
        check(drive == 1'b0, "R2 glitch ignored drive", drive, 0);
        // R2 / R3: exactly the window.
        uv_ok[2] = 1'b0;
        repeat (FILT) tick();
        check(drive == 1'b1, "R3 fault drives line", drive, 1);
        check(done_n == 1'b1, "R3 fault clears done", done_n, 1);
        check(gate == '1, "R3 gates before kill edge", gate, 15);
        tick();
        check(gate == '0, "R3 gates killed", gate, 0);
        // R4: recovery with enable low and a pulse inside the window.
        enable = 1'b0;
        uv_ok[2] = 1'b1;
        tick();
        check(drive == 1'b0, "R4 drive released", drive, 0);
        repeat (5) tick();
        enable = 1'b1;
        tick();
        enable = 1'b0;
        repeat (STAB + 20) tick();
        check(gate == '0, "R4 enable ignored in window", gate, 0);
        enable = 1'b1;
        measure_on(0, "R5 rise from idle after window");

        // R8: external pull-down.
        ext_rel = 1'b0;
        tick();
        check(gate == '0, "R8 immediate kill", gate, 0);
        check(drive == 1'b0, "R8 no own drive", drive, 0);
        check(done_n == 1'b1, "R8 done cleared", done_n, 1);
        repeat (10) tick();
        // R9: zero-wait restart on external release.
        rand_delays();
        ext_rel = 1'b1;
        measure_on(0, "R9 zero-wait rise");
        measure_off('1, "R6 fall timing");

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule